// File: doc/BRIEF.md
# Tagged Snooping Memory Arbiter

This block funnels memory traffic from several processor caches and one command channel onto a single downstream memory port. Every forwarded request carries the index of the channel it came from as a tag. The memory echoes that tag on its response, and the block uses it to send the response back to the right requester. Each processor sees a private, narrower address space. On the way down, the block prepends the processor's own index to the address as a region prefix. On the way back, it removes that prefix again. The command channel addresses the whole memory directly.

Command-channel accesses are kept coherent with the processor caches through snoops. Before a command write is forwarded, every cache receives a one-cycle write snoop. Before a command read is forwarded, every cache receives a read snoop, and the memory read is held back until each cache has answered. If any cache answers with data, that data is returned in place of the memory data. The block keeps at most one request outstanding downstream, and it picks the next channel in rotating order. The memory side may stall for any number of cycles, on both the request and the response.

Top module: `snoop_mem_arbiter`

## Requirements
- R1: After reset, `req_ready`, `rsp_valid`, `mem_req_valid` and `snp_valid` are all low.
- R2: At most one `req_ready` bit is high in any cycle. Grants rotate from the channel after the last one granted, so a channel that keeps requesting sees at most CH-1 grants to other channels before its own.
- R3: After a request is accepted, no other request is accepted until its response has been delivered.
- R4: `mem_req_tag` carries the accepted channel's index: processors are 0..NPROC-1 and the command channel is NPROC.
- R5: For processor i, `mem_req_addr` is {i as PW bits, the low LAW bits of its request address}. A command request forwards its full FAW-bit address unchanged.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, the request fields stay valid and unchanged.
- R7: One cycle after `mem_rsp_valid`, exactly one `rsp_valid` bit is high: the bit indexed by `mem_rsp_tag`.
- R8: A response to a processor carries only the low LAW bits of `mem_rsp_addr`, with the upper PW bits zero. A response to the command channel carries the full address.
- R9: A command write produces a one-cycle `snp_valid` with `snp_write`=1 and `snp_addr` equal to the request address, before the write is issued to memory. Processor requests produce no snoop.
- R10: A command read produces a one-cycle `snp_valid` with `snp_write`=0. The memory read is issued only after every cache has pulsed `snr_valid` for that snoop. Answers are taken from the cycle after the snoop onward.
- R11: For a command read, if any cache answered with `snr_hit`=1, `rsp_data` is the data of the lowest-indexed hitting cache. Otherwise it is `mem_rsp_data`.
- R12: For writes and processor reads, `rsp_data` equals `mem_rsp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | CH | Request valid per channel (index NPROC is the command channel) |
| req_ready | output | CH | Request accepted this cycle, per channel |
| req_write | input | CH | Request is a write, per channel |
| req_addr | input | CH*FAW | Request address per channel; processors use the low LAW bits |
| req_wdata | input | CH*DW | Write data per channel |
| rsp_valid | output | CH | Response strobe per channel |
| rsp_addr | output | FAW | Response address (stripped for processors) |
| rsp_data | output | DW | Response data |
| mem_req_valid | output | 1 | Downstream request valid |
| mem_req_ready | input | 1 | Downstream request accepted |
| mem_req_write | output | 1 | Downstream request is a write |
| mem_req_tag | output | TAGW | Channel tag of the downstream request |
| mem_req_addr | output | FAW | Prefixed downstream address |
| mem_req_wdata | output | DW | Downstream write data |
| mem_rsp_valid | input | 1 | Downstream response valid |
| mem_rsp_tag | input | TAGW | Tag returned with the response |
| mem_rsp_addr | input | FAW | Address returned with the response |
| mem_rsp_data | input | DW | Data returned with the response |
| snp_valid | output | 1 | Snoop strobe to all caches |
| snp_write | output | 1 | Snoop is for a write |
| snp_addr | output | FAW | Full snooped address |
| snr_valid | input | NPROC | Snoop answer strobe per cache |
| snr_hit | input | NPROC | Snoop answer carries data |
| snr_data | input | NPROC*DW | Snoop answer data per cache |

## Verification
The stimulus targets the corner cases that break coherence. These include command reads where every cache hits, so a wrong priority would return a higher-indexed cache's data, and command reads where no cache hits, so stale snoop data would leak into the response. Snoop answers arrive at scattered times, so a design that issued the memory read before the last answer would be caught at the memory port. Processor addresses at the top and bottom of the local range expose prefix and strip errors at the region boundaries. The memory model echoes tags and addresses after random delays and stalls randomly, so misrouted responses, fields that drift during a stall, and unfair rotation under continuous requests all appear as mismatches.

// File: rtl/sma_pkg.sv
package sma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SNOOP,
    ST_SWAIT,
    ST_ISSUE,
    ST_MWAIT
  } sma_state_e;
endpackage

// File: rtl/sma_rr_arb.sv
module sma_rr_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] ptr;

  // Search from the pointer upward, wrapping once.
  always_comb begin
    logic found;
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = int'(ptr) + off;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        gnt_idx  = IW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv) ptr <= (gnt_idx == LAST) ? '0 : gnt_idx + 1'b1;
  end
endmodule

// File: rtl/sma_snoop_track.sv
module sma_snoop_track #(
  parameter int NPROC = 3,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                collect,
  input  logic [NPROC-1:0]    snr_valid,
  input  logic [NPROC-1:0]    snr_hit,
  input  logic [NPROC*DW-1:0] snr_data,
  output logic                all_in,
  output logic                any_hit,
  output logic [DW-1:0]       hit_data
);
  logic [NPROC-1:0] seen;
  logic [NPROC-1:0] hit;
  logic [DW-1:0]    hdata [NPROC];

  assign all_in  = &(seen | (collect ? snr_valid : '0));
  assign any_hit = |hit;

  // Lowest-indexed hitting cache wins.
  always_comb begin
    hit_data = '0;
    for (int i = NPROC - 1; i >= 0; i--)
      if (hit[i]) hit_data = hdata[i];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen <= '0;
      hit  <= '0;
    end else if (collect) begin
      seen <= seen | snr_valid;
      for (int i = 0; i < NPROC; i++)
        if (snr_valid[i] && snr_hit[i]) begin
          hit[i]   <= 1'b1;
          hdata[i] <= snr_data[i*DW +: DW];
        end
    end
  end
endmodule

// File: rtl/sma_resp_route.sv
module sma_resp_route #(
  parameter int CH   = 4,
  parameter int LAW  = 8,
  parameter int FAW  = 10,
  parameter int DW   = 16,
  parameter int TAGW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [TAGW-1:0] tag,
  input  logic [FAW-1:0]  addr,
  input  logic [DW-1:0]   mem_data,
  input  logic            use_snoop,
  input  logic [DW-1:0]   snoop_data,
  output logic [CH-1:0]   rsp_valid,
  output logic [FAW-1:0]  rsp_addr,
  output logic [DW-1:0]   rsp_data
);
  localparam logic [TAGW-1:0] CMD_TAG = TAGW'(CH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= '0;
      rsp_addr  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= '0;
      if (fire) begin
        rsp_valid[tag] <= 1'b1;
        rsp_addr       <= (tag == CMD_TAG) ? addr : FAW'(addr[LAW-1:0]);
        rsp_data       <= use_snoop ? snoop_data : mem_data;
      end
    end
  end
endmodule

// File: rtl/snoop_mem_arbiter.sv
module snoop_mem_arbiter
  import sma_pkg::*;
#(
  parameter int NPROC = 3,
  parameter int LAW   = 8,
  parameter int DW    = 16,
  localparam int CH   = NPROC + 1,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int FAW  = PW + LAW,
  localparam int TAGW = $clog2(CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CH-1:0]       req_valid,
  output logic [CH-1:0]       req_ready,
  input  logic [CH-1:0]       req_write,
  input  logic [CH*FAW-1:0]   req_addr,
  input  logic [CH*DW-1:0]    req_wdata,
  output logic [CH-1:0]       rsp_valid,
  output logic [FAW-1:0]      rsp_addr,
  output logic [DW-1:0]       rsp_data,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [TAGW-1:0]     mem_req_tag,
  output logic [FAW-1:0]      mem_req_addr,
  output logic [DW-1:0]       mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [TAGW-1:0]     mem_rsp_tag,
  input  logic [FAW-1:0]      mem_rsp_addr,
  input  logic [DW-1:0]       mem_rsp_data,
  output logic                snp_valid,
  output logic                snp_write,
  output logic [FAW-1:0]      snp_addr,
  input  logic [NPROC-1:0]    snr_valid,
  input  logic [NPROC-1:0]    snr_hit,
  input  logic [NPROC*DW-1:0] snr_data
);
  localparam logic [TAGW-1:0] CMD_CH = TAGW'(NPROC);

  sma_state_e      state;
  logic [TAGW-1:0] cur_ch;
  logic            cur_write;
  logic [FAW-1:0]  cur_addr;
  logic [DW-1:0]   cur_wdata;

  logic [CH-1:0]   gnt;
  logic [TAGW-1:0] gnt_idx;
  logic            take;
  logic            all_in, any_hit;
  logic [DW-1:0]   hit_data;
  logic [FAW-1:0]  sel_addr;

  assign take = (state == ST_IDLE) && (|req_valid);

  sma_rr_arb #(.N(CH), .IW(TAGW)) u_arb (
    .clk(clk), .rst(rst), .req(req_valid), .adv(take),
    .gnt(gnt), .gnt_idx(gnt_idx)
  );

  sma_snoop_track #(.NPROC(NPROC), .DW(DW)) u_snp (
    .clk(clk), .rst(rst),
    .clear(state == ST_SNOOP), .collect(state == ST_SWAIT),
    .snr_valid(snr_valid), .snr_hit(snr_hit), .snr_data(snr_data),
    .all_in(all_in), .any_hit(any_hit), .hit_data(hit_data)
  );

  sma_resp_route #(.CH(CH), .LAW(LAW), .FAW(FAW), .DW(DW), .TAGW(TAGW)) u_route (
    .clk(clk), .rst(rst),
    .fire((state == ST_MWAIT) && mem_rsp_valid),
    .tag(mem_rsp_tag), .addr(mem_rsp_addr), .mem_data(mem_rsp_data),
    .use_snoop((cur_ch == CMD_CH) && !cur_write && any_hit),
    .snoop_data(hit_data),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  // Processor channels get their index as region prefix.
  always_comb begin
    sel_addr = req_addr[gnt_idx*FAW +: FAW];
    if (gnt_idx != CMD_CH)
      sel_addr = {gnt_idx[PW-1:0], sel_addr[LAW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_ch    <= '0;
      cur_write <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (take) begin
          cur_ch    <= gnt_idx;
          cur_write <= req_write[gnt_idx];
          cur_addr  <= sel_addr;
          cur_wdata <= req_wdata[gnt_idx*DW +: DW];
          state     <= (gnt_idx == CMD_CH) ? ST_SNOOP : ST_ISSUE;
        end
        ST_SNOOP: state <= cur_write ? ST_ISSUE : ST_SWAIT;
        ST_SWAIT: if (all_in) state <= ST_ISSUE;
        ST_ISSUE: if (mem_req_ready) state <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE) ? gnt : '0;
  assign mem_req_valid = (state == ST_ISSUE);
  assign mem_req_write = cur_write;
  assign mem_req_tag   = cur_ch;
  assign mem_req_addr  = cur_addr;
  assign mem_req_wdata = cur_wdata;
  assign snp_valid     = (state == ST_SNOOP);
  assign snp_write     = cur_write;
  assign snp_addr      = cur_addr;
endmodule

// File: rtl/sma_checker.sv
module sma_checker #(
  parameter int NPROC = 3,
  parameter int LAW   = 8,
  parameter int DW    = 16,
  localparam int CH   = NPROC + 1,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int FAW  = PW + LAW,
  localparam int TAGW = $clog2(CH)
) (
  input logic            clk,
  input logic            rst,
  input logic [CH-1:0]   req_ready,
  input logic [CH-1:0]   rsp_valid,
  input logic [FAW-1:0]  rsp_addr,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_write,
  input logic [TAGW-1:0] mem_req_tag,
  input logic [FAW-1:0]  mem_req_addr,
  input logic [DW-1:0]   mem_req_wdata,
  input logic            mem_rsp_valid,
  input logic [TAGW-1:0] mem_rsp_tag,
  input logic            snp_valid,
  input logic            wait_rsp
);
  a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));

  a_r3_no_accept_while_out: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> (req_ready == '0));

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_tag)
       && $stable(mem_req_write) && $stable(mem_req_wdata)));

  a_r7_route_by_tag: assert property (@(posedge clk) disable iff (rst)
    (wait_rsp && mem_rsp_valid) |=>
      (rsp_valid[$past(mem_rsp_tag)] && $countones(rsp_valid) == 1));

  a_r9_snoop_pulse: assert property (@(posedge clk) disable iff (rst)
    snp_valid |=> !snp_valid);

  for (genvar i = 0; i < NPROC; i++) begin : g_strip
    a_r8_strip_prefix: assert property (@(posedge clk) disable iff (rst)
      rsp_valid[i] |-> (rsp_addr[FAW-1:LAW] == '0));
  end
endmodule

bind snoop_mem_arbiter sma_checker #(.NPROC(NPROC), .LAW(LAW), .DW(DW)) u_sma_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_addr(rsp_addr), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_tag(mem_req_tag),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
  .snp_valid(snp_valid), .wait_rsp(state == sma_pkg::ST_MWAIT)
);

// File: tb/test_snoop_mem_arbiter.sv
`timescale 1ns/1ps
module test_snoop_mem_arbiter;
  localparam int NPROC = 3;
  localparam int LAW   = 8;
  localparam int DW    = 16;
  localparam int CH    = NPROC + 1;
  localparam int PW    = (NPROC > 1) ? $clog2(NPROC) : 1;
  localparam int FAW   = PW + LAW;
  localparam int TAGW  = $clog2(CH);
  localparam int TOTAL = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [CH-1:0]       req_valid = '0, req_ready, req_write = '0;
  logic [CH*FAW-1:0]   req_addr = '0;
  logic [CH*DW-1:0]    req_wdata = '0;
  logic [CH-1:0]       rsp_valid;
  logic [FAW-1:0]      rsp_addr;
  logic [DW-1:0]       rsp_data;
  logic                mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [TAGW-1:0]     mem_req_tag;
  logic [FAW-1:0]      mem_req_addr;
  logic [DW-1:0]       mem_req_wdata;
  logic                mem_rsp_valid = 1'b0;
  logic [TAGW-1:0]     mem_rsp_tag = '0;
  logic [FAW-1:0]      mem_rsp_addr = '0;
  logic [DW-1:0]       mem_rsp_data = '0;
  logic                snp_valid, snp_write;
  logic [FAW-1:0]      snp_addr;
  logic [NPROC-1:0]    snr_valid = '0, snr_hit = '0;
  logic [NPROC*DW-1:0] snr_data = '0;

  snoop_mem_arbiter #(.NPROC(NPROC), .LAW(LAW), .DW(DW)) i_snoop_mem_arbiter (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // Bench state
  bit             busy [CH];
  logic [FAW-1:0] p_addr [CH];
  bit             p_write [CH];
  logic [DW-1:0]  p_wdata [CH];
  logic [DW-1:0]  exp_data [CH];
  int             waits [CH];
  logic [DW-1:0]  mem [1 << FAW];
  bit             m_pend = 0;
  int             m_dly = 0;
  logic [TAGW-1:0] m_tag;
  logic [FAW-1:0] m_addr;
  logic [DW-1:0]  m_data;
  int             snr_cnt [NPROC];
  bit             s_hit [NPROC];
  logic [DW-1:0]  s_dat [NPROC];
  int             snoops_open = 0;
  bit             cmd_snooped = 0;
  int             launches = 0;
  int             n_out = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [FAW-1:0] down_addr(int ch, logic [FAW-1:0] a);
    if (ch == NPROC) return a;
    return {PW'(ch), a[LAW-1:0]};
  endfunction

  function automatic logic [FAW-1:0] up_addr(int ch, logic [FAW-1:0] a);
    if (ch == NPROC) return a;
    return FAW'(a[LAW-1:0]);
  endfunction

  function automatic int snoop_mode();
    if (launches < 20) return 1;       // every cache hits
    if (launches < 40) return 2;       // no cache hits
    return 0;                          // random
  endfunction

  task automatic launch(int ch);
    logic [FAW-1:0] a;
    if (ch == NPROC) a = FAW'($urandom);
    else if (launches < 20) a = ($urandom % 2) ? FAW'({LAW{1'b1}}) : '0;
    else a = FAW'($urandom % (1 << LAW));
    p_addr[ch]  = a;
    p_write[ch] = ($urandom % 2) == 1;
    p_wdata[ch] = DW'($urandom);
    if (ch == NPROC) cmd_snooped = 0;
    req_addr[ch*FAW +: FAW] = a;
    req_write[ch]           = p_write[ch];
    req_wdata[ch*DW +: DW]  = p_wdata[ch];
    req_valid[ch]           = 1'b1;
    busy[ch]                = 1;
    waits[ch]               = 0;
    launches++;
  endtask

  initial begin
    bit fire [CH];
    void'($urandom(32'h5a17));
    for (int k = 0; k < (1 << FAW); k++) mem[k] = DW'(k * 37 + 11);
    for (int i = 0; i < CH; i++) begin busy[i] = 0; waits[i] = 0; end
    for (int i = 0; i < NPROC; i++) begin snr_cnt[i] = 0; s_hit[i] = 0; s_dat[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(req_ready == '0, "R1", "req_ready after reset", 32'(req_ready), 0);
    chk(rsp_valid == '0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    chk(!mem_req_valid, "R1", "mem_req_valid after reset", 32'(mem_req_valid), 0);
    chk(!snp_valid, "R1", "snp_valid after reset", 32'(snp_valid), 0);

    forever begin
      @(negedge clk);
      // Responses (R7, R8, R11, R12)
      for (int i = 0; i < CH; i++) if (rsp_valid[i]) begin
        chk(busy[i] && !req_valid[i], "R7", $sformatf("unexpected response ch%0d", i),
            32'(rsp_valid), 0);
        chk(rsp_addr == up_addr(i, p_addr[i]), "R8", $sformatf("rsp_addr ch%0d", i),
            32'(rsp_addr), 32'(up_addr(i, p_addr[i])));
        chk(rsp_data == exp_data[i], (i == NPROC && !p_write[i]) ? "R11" : "R12",
            $sformatf("rsp_data ch%0d", i), 32'(rsp_data), 32'(exp_data[i]));
        busy[i] = 0;
        n_out--;
      end
      // Grants (R2, R3)
      chk($countones(req_ready) <= 1, "R2", "more than one grant", 32'(req_ready), 0);
      for (int i = 0; i < CH; i++) fire[i] = req_valid[i] && req_ready[i];
      for (int i = 0; i < CH; i++) if (fire[i]) begin
        chk(n_out == 0, "R3", "accept while outstanding", 32'(n_out), 0);
        n_out++;
        waits[i] = 0;
        for (int j = 0; j < CH; j++) if (j != i && req_valid[j]) begin
          waits[j]++;
          chk(waits[j] <= CH - 1, "R2", $sformatf("starvation ch%0d", j),
              32'(waits[j]), 32'(CH - 1));
        end
      end
      // Snoops (R9, R10)
      if (snp_valid) begin
        chk(busy[NPROC] && !req_valid[NPROC], "R9", "snoop without command request",
            32'(snp_valid), 0);
        chk(snp_addr == p_addr[NPROC], "R9", "snp_addr", 32'(snp_addr), 32'(p_addr[NPROC]));
        chk(snp_write == p_write[NPROC], "R10", "snp_write", 32'(snp_write),
            32'(p_write[NPROC]));
        cmd_snooped = 1;
        if (!snp_write) begin
          snoops_open = NPROC;
          for (int c = 0; c < NPROC; c++) begin
            snr_cnt[c] = 1 + int'($urandom % 4);
            case (snoop_mode())
              1: s_hit[c] = 1;
              2: s_hit[c] = 0;
              default: s_hit[c] = ($urandom % 3) == 0;
            endcase
            s_dat[c] = DW'($urandom);
          end
        end
      end
      // Memory accept (R4, R5, R9, R10)
      if (mem_req_valid && mem_req_ready) begin
        int t;
        t = int'(mem_req_tag);
        chk(t < CH && busy[t] && !req_valid[t], "R4", "tag of accepted channel",
            32'(mem_req_tag), 0);
        if (t < CH) begin
          chk(mem_req_addr == down_addr(t, p_addr[t]), "R5", $sformatf("prefix ch%0d", t),
              32'(mem_req_addr), 32'(down_addr(t, p_addr[t])));
          chk(mem_req_write == p_write[t] && (!p_write[t] || mem_req_wdata == p_wdata[t]),
              "R4", "request fields", 32'(mem_req_wdata), 32'(p_wdata[t]));
          if (t == NPROC) begin
            chk(cmd_snooped, p_write[t] ? "R9" : "R10", "memory before snoop", 0, 1);
            chk(snoops_open == 0, "R10", "memory before all snoop answers",
                32'(snoops_open), 0);
          end
          m_data = p_write[t] ? p_wdata[t] : mem[mem_req_addr];
          if (p_write[t]) mem[mem_req_addr] = p_wdata[t];
          exp_data[t] = m_data;
          if (t == NPROC && !p_write[t])
            for (int c = NPROC - 1; c >= 0; c--) if (s_hit[c]) exp_data[t] = s_dat[c];
        end
        m_pend = 1;
        m_dly  = 1 + int'($urandom % 3);
        m_tag  = mem_req_tag;
        m_addr = mem_req_addr;
      end

      @(posedge clk);
      #1;
      for (int i = 0; i < CH; i++) if (fire[i]) req_valid[i] = 1'b0;
      mem_rsp_valid = 1'b0;
      if (m_pend) begin
        m_dly--;
        if (m_dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_tag   = m_tag;
          mem_rsp_addr  = m_addr;
          mem_rsp_data  = m_data;
          m_pend        = 0;
        end
      end
      mem_req_ready = ($urandom % 2) == 1;
      for (int c = 0; c < NPROC; c++) begin
        snr_valid[c] = (snr_cnt[c] == 1);
        snr_hit[c]   = snr_valid[c] && s_hit[c];
        snr_data[c*DW +: DW] = snr_valid[c] ? s_dat[c] : DW'($urandom);
        if (snr_valid[c]) snoops_open--;
        if (snr_cnt[c] > 0) snr_cnt[c]--;
      end
      for (int i = 0; i < CH; i++)
        if (!busy[i] && launches < TOTAL && ($urandom % 2) == 0) launch(i);
      if (launches >= TOTAL && n_out == 0 && req_valid == '0 && !m_pend) begin
        bit idle;
        idle = 1;
        for (int i = 0; i < CH; i++) if (busy[i]) idle = 0;
        if (idle) begin
          finished = 1;
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog: actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule